// File: doc/BRIEF.md
# Two-Bank Interrupt Source Controller

This block collects up to 64 interrupt inputs, split into a low bank (sources 0 to 31) and a high bank (sources 32 to 63), and presents them to a processor as one interrupt request line. Every input first passes through a synchroniser. Each bank then keeps an event register, an enable register, a write-one-to-clear acknowledge register and a read-only raw level register. A fixed per-bank mask declares some sources level type. Edge-type sources latch a rising edge into the event register. Level-type sources are pending for as long as their input is high and they are enabled.

Software reaches the registers through a simple word-wide register bus inside a 64-byte window. It enables sources, polls the enable register to confirm a mask change, and clears handled edge events by writing ones to the acknowledge register. Besides the combined request, the block drives a helper pair: a valid flag and the 6-bit number of the highest-numbered pending source. Because the high bank holds the higher numbers, it wins over the low bank.

A small response state machine sequences the bus. It has two states. In `BUS_IDLE` no read data is being presented. In `BUS_RESP` the read data captured on the previous edge is on the bus with its valid flag high. Two transitions are named: `go_resp` is taken from either state when a read is accepted, and `go_idle` is taken from either state on any cycle without a read.

Top module: `mmio_irq_ctrl`

## Requirements
- R1: Register window decoding:
  - Address bits [5:4] select the bank: 2'b10 (byte offset 0x20) is the low bank and 2'b01 (offset 0x10) is the high bank.
  - Address bits [3:2] select the register: 0 event, 1 enable, 2 acknowledge, 3 level.
  - Bit n of a bank's data word belongs to source n of that bank (n, or 32+n in the high bank).
  - Reads of offsets 0x00–0x0F and 0x30–0x3F, and reads of any acknowledge register, return zero.
- R2: A read accepted on a clock edge raises the read-valid output with the read data for exactly the following cycle, unless another read is accepted on that edge.
- R3: Writing a word to a bank's acknowledge register clears the event bits where the word holds 1 and leaves the other event bits untouched. If a new edge sets a bit in the same cycle as an acknowledge clears it, the set wins.
- R4: The enable register of each bank reads back the last value written to it.
- R5: A 0-to-1 transition of a synchronised edge-type input whose enable bit is set latches its event bit. Setting an enable bit while that input is already high latches nothing and raises no request.
- R6: After reset all enable and event bits are zero, and the request and helper valid outputs are low.
- R7: Level-type sources are low-bank bits 20–28 by default (mask 0x1ff00000) and none in the high bank. Their event bit is never set. Such a source is pending while it is enabled and its synchronised input is high.
- R8: The helper outputs report the highest-numbered pending source, where pending means enabled and either event set or level-type with input high. The valid flag is low when nothing is pending.
- R9: The request output is high exactly when at least one source in either bank is pending. It follows register state with no further delay.
- R10: The level register returns the synchronised inputs of all 32 bank bits, whatever their type or enable. Writes to event and level registers change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_src_i | input | 64 | Raw interrupt inputs, bit n is source n |
| bus_req_i | input | 1 | Bus access strobe, one access per cycle |
| bus_wr_i | input | 1 | 1 for write, 0 for read |
| bus_addr_i | input | 6 | Byte address inside the 64-byte window |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid with bus_rvalid_o |
| bus_rvalid_o | output | 1 | Read data valid, one cycle after a read |
| irq_o | output | 1 | Combined interrupt request |
| top_valid_o | output | 1 | A pending source exists |
| top_num_o | output | 6 | Number of the highest pending source |

## Verification
The bench builds the block with its default parameters: two synchroniser stages, low-bank level mask 0x1ff00000 and no level-type sources in the high bank. This mix places edge-type and level-type sources side by side in the low bank, so the bench can check priority between them. It can also check priority across the bank boundary against an always-edge high bank. Random toggling of all 64 inputs, mixed with random enable, acknowledge and ignored writes, reaches overlapping pending sets. Directed cases cover enabling a source that is already high, acknowledging with zero, and unmapped offsets.

// File: rtl/mmio_irq_pkg.sv
package mmio_irq_pkg;

    localparam int BANK_W    = 32;
    localparam int NUM_BANKS = 2;
    localparam int SRC_W     = BANK_W * NUM_BANKS;
    localparam int SRC_IDX_W = $clog2(SRC_W);
    localparam int ADDR_W    = 6;

    typedef enum logic [1:0] {
        REG_EVENT  = 2'd0,
        REG_ENABLE = 2'd1,
        REG_ACK    = 2'd2,
        REG_LEVEL  = 2'd3
    } reg_sel_e;

    typedef enum logic {
        BUS_IDLE = 1'b0,
        BUS_RESP = 1'b1
    } bus_state_e;

    // bank 0 (low sources) decodes at 0x20, bank 1 (high sources) at 0x10
    function automatic logic [1:0] bank_code(input int b);
        return (b == 0) ? 2'b10 : 2'b01;
    endfunction

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int W      = 64,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d_i;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q_o = stg[STAGES-1];

endmodule

// File: rtl/irq_bank.sv
module irq_bank #(
    parameter int           W          = 32,
    parameter logic [W-1:0] LEVEL_MASK = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] sync_i,
    input  logic         en_we_i,
    input  logic         ack_we_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] event_o,
    output logic [W-1:0] enable_o,
    output logic [W-1:0] pend_o
);

    logic [W-1:0] prev_q;
    logic [W-1:0] event_q;
    logic [W-1:0] enable_q;
    logic [W-1:0] rise;
    logic [W-1:0] set_bits;
    logic [W-1:0] clr_bits;
    logic [W-1:0] event_d;

    always_comb begin
        rise     = sync_i & ~prev_q;
        set_bits = rise & enable_q & ~LEVEL_MASK;
        clr_bits = ack_we_i ? wdata_i : '0;
        event_d  = (event_q & ~clr_bits) | set_bits;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q   <= '0;
            event_q  <= '0;
            enable_q <= '0;
        end else begin
            prev_q  <= sync_i;
            event_q <= event_d;
            if (en_we_i) enable_q <= wdata_i;
        end
    end

    assign event_o  = event_q;
    assign enable_o = enable_q;
    assign pend_o   = enable_q & (event_q | (sync_i & LEVEL_MASK));

endmodule

// File: rtl/irq_prio.sv
module irq_prio #(
    parameter int N  = 64,
    parameter int IW = 6
) (
    input  logic [N-1:0]  pend_i,
    output logic          valid_o,
    output logic [IW-1:0] num_o
);

    always_comb begin
        num_o = '0;
        for (int i = 0; i < N; i++) begin
            if (pend_i[i]) num_o = i[IW-1:0];
        end
        valid_o = |pend_i;
    end

endmodule

// File: rtl/mmio_irq_ctrl.sv
module mmio_irq_ctrl
    import mmio_irq_pkg::*;
#(
    parameter int                SYNC_STAGES   = 2,
    parameter logic [BANK_W-1:0] LO_LEVEL_MASK = 32'h1ff0_0000,
    parameter logic [BANK_W-1:0] HI_LEVEL_MASK = 32'h0000_0000
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [SRC_W-1:0]     irq_src_i,
    input  logic                 bus_req_i,
    input  logic                 bus_wr_i,
    input  logic [ADDR_W-1:0]    bus_addr_i,
    input  logic [BANK_W-1:0]    bus_wdata_i,
    output logic [BANK_W-1:0]    bus_rdata_o,
    output logic                 bus_rvalid_o,
    output logic                 irq_o,
    output logic                 top_valid_o,
    output logic [SRC_IDX_W-1:0] top_num_o
);

    logic [SRC_W-1:0]  sync_all;
    logic [SRC_W-1:0]  pend_all;
    logic [SRC_W-1:0]  ev_all;
    logic [SRC_W-1:0]  en_all;
    logic [1:0]        addr_bank;
    reg_sel_e          addr_reg;
    logic              wr_acc;
    logic              rd_acc;

    assign addr_bank = bus_addr_i[5:4];
    assign addr_reg  = reg_sel_e'(bus_addr_i[3:2]);
    assign wr_acc    = bus_req_i &  bus_wr_i;
    assign rd_acc    = bus_req_i & ~bus_wr_i;

    irq_sync #(.W(SRC_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (irq_src_i),
        .q_o   (sync_all)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        localparam logic [BANK_W-1:0] MASK = (b == 0) ? LO_LEVEL_MASK : HI_LEVEL_MASK;
        logic sel;
        assign sel = (addr_bank == bank_code(b));

        irq_bank #(.W(BANK_W), .LEVEL_MASK(MASK)) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .sync_i   (sync_all[b*BANK_W +: BANK_W]),
            .en_we_i  (wr_acc && sel && (addr_reg == REG_ENABLE)),
            .ack_we_i (wr_acc && sel && (addr_reg == REG_ACK)),
            .wdata_i  (bus_wdata_i),
            .event_o  (ev_all[b*BANK_W +: BANK_W]),
            .enable_o (en_all[b*BANK_W +: BANK_W]),
            .pend_o   (pend_all[b*BANK_W +: BANK_W])
        );
    end

    irq_prio #(.N(SRC_W), .IW(SRC_IDX_W)) u_prio (
        .pend_i  (pend_all),
        .valid_o (top_valid_o),
        .num_o   (top_num_o)
    );

    assign irq_o = |pend_all;

    // read mux
    logic [BANK_W-1:0] rd_mux;
    always_comb begin
        rd_mux = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (addr_bank == bank_code(b)) begin
                unique case (addr_reg)
                    REG_EVENT:  rd_mux = ev_all[b*BANK_W +: BANK_W];
                    REG_ENABLE: rd_mux = en_all[b*BANK_W +: BANK_W];
                    REG_ACK:    rd_mux = '0;
                    REG_LEVEL:  rd_mux = sync_all[b*BANK_W +: BANK_W];
                endcase
            end
        end
    end

    // bus response state machine
    bus_state_e        state_q, state_d;
    logic [BANK_W-1:0] rdata_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= BUS_IDLE;
            rdata_q <= '0;
        end else begin
            state_q <= state_d;
            if (rd_acc) rdata_q <= rd_mux;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_IDLE: state_d = rd_acc ? BUS_RESP : BUS_IDLE;  // go_resp
            BUS_RESP: state_d = rd_acc ? BUS_RESP : BUS_IDLE;  // go_idle
        endcase
    end

    always_comb begin
        bus_rvalid_o = (state_q == BUS_RESP);
        bus_rdata_o  = bus_rvalid_o ? rdata_q : '0;
    end

endmodule

// File: rtl/mmio_irq_ctrl_chk.sv
module mmio_irq_ctrl_chk
    import mmio_irq_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 bus_req_i,
    input logic                 bus_wr_i,
    input logic [ADDR_W-1:0]    bus_addr_i,
    input logic [BANK_W-1:0]    bus_wdata_i,
    input logic                 bus_rvalid_o,
    input logic                 irq_o,
    input logic                 top_valid_o,
    input logic [SRC_IDX_W-1:0] top_num_o,
    input logic [SRC_W-1:0]     pend_all,
    input logic [SRC_W-1:0]     ev_all,
    input logic [SRC_W-1:0]     en_all
);

    p_read_resp_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_i && !bus_wr_i) |=> bus_rvalid_o);

    p_ack_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_i && bus_wr_i && bus_addr_i[5:2] == 4'b1010 && bus_wdata_i[0] && !en_all[0])
        |=> !ev_all[0]);

    p_enable_readback_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_i && bus_wr_i && bus_addr_i[5:2] == 4'b1001)
        |=> (en_all[BANK_W-1:0] == $past(bus_wdata_i)));

    p_event_needs_enable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((ev_all & ~$past(ev_all) & ~$past(en_all)) == '0));

    p_prio_top_r8: assert property (@(posedge clk) disable iff (!rst_n)
        top_valid_o |-> ((pend_all >> top_num_o) == SRC_W'(1)));

    p_irq_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == top_valid_o);

endmodule

bind mmio_irq_ctrl mmio_irq_ctrl_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_req_i    (bus_req_i),
    .bus_wr_i     (bus_wr_i),
    .bus_addr_i   (bus_addr_i),
    .bus_wdata_i  (bus_wdata_i),
    .bus_rvalid_o (bus_rvalid_o),
    .irq_o        (irq_o),
    .top_valid_o  (top_valid_o),
    .top_num_o    (top_num_o),
    .pend_all     (pend_all),
    .ev_all       (ev_all),
    .en_all       (en_all)
);

// File: tb/mmio_irq_ctrl_tb_top.sv
module mmio_irq_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] LO_LVL = 32'h1ff0_0000;
    localparam logic [63:0] LVL    = {32'h0, LO_LVL};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] irq_src = '0;
    logic        bus_req = 1'b0;
    logic        bus_wr = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;
    logic        irq;
    logic        top_valid;
    logic [5:0]  top_num;

    int n_cmp = 0;
    int n_bad = 0;

    // bench model
    logic [63:0] m_en = '0;
    logic [63:0] m_ev = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mmio_irq_ctrl dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .irq_src_i    (irq_src),
        .bus_req_i    (bus_req),
        .bus_wr_i     (bus_wr),
        .bus_addr_i   (bus_addr),
        .bus_wdata_i  (bus_wdata),
        .bus_rdata_o  (bus_rdata),
        .bus_rvalid_o (bus_rvalid),
        .irq_o        (irq),
        .top_valid_o  (top_valid),
        .top_num_o    (top_num)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (5) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic bus_write(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_req = 1'b0; bus_wr = 1'b0;
        if (a == 6'h24) m_en[31:0]  = d;
        if (a == 6'h14) m_en[63:32] = d;
        if (a == 6'h28) m_ev[31:0]  = m_ev[31:0]  & ~d;
        if (a == 6'h18) m_ev[63:32] = m_ev[63:32] & ~d;
    endtask

    task automatic bus_read(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(posedge clk);
        @(negedge clk);
        bus_req = 1'b0;
        chk("R2 rvalid", 64'(bus_rvalid), 64'd1);
        d = bus_rdata;
    endtask

    task automatic drive_src(input logic [63:0] v);
        m_ev = m_ev | (v & ~irq_src & m_en & ~LVL);
        irq_src = v;
        settle();
    endtask

    function automatic logic [63:0] exp_pend();
        return m_en & (m_ev | (irq_src & LVL));
    endfunction

    function automatic logic [5:0] exp_num(input logic [63:0] p);
        logic [5:0] n = '0;
        for (int i = 0; i < 64; i++) if (p[i]) n = i[5:0];
        return n;
    endfunction

    task automatic check_outputs(input string tag);
        logic [63:0] p;
        p = exp_pend();
        chk({tag, " R9 irq"}, 64'(irq), 64'(|p));
        chk({tag, " R8 valid"}, 64'(top_valid), 64'(|p));
        if (|p) chk({tag, " R8 num"}, 64'(top_num), 64'(exp_num(p)));
    endtask

    task automatic check_regs(input string tag);
        logic [31:0] d;
        bus_read(6'h20, d); chk({tag, " R1 event lo"}, 64'(d), 64'(m_ev[31:0]));
        bus_read(6'h10, d); chk({tag, " R1 event hi"}, 64'(d), 64'(m_ev[63:32]));
        bus_read(6'h24, d); chk({tag, " R4 enable lo"}, 64'(d), 64'(m_en[31:0]));
        bus_read(6'h14, d); chk({tag, " R4 enable hi"}, 64'(d), 64'(m_en[63:32]));
        bus_read(6'h2C, d); chk({tag, " R10 level lo"}, 64'(d), 64'(irq_src[31:0]));
        bus_read(6'h1C, d); chk({tag, " R10 level hi"}, 64'(d), 64'(irq_src[63:32]));
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : main
        logic [31:0] d;
        void'($urandom(32'h1234_5678));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R6 reset state
        chk("R6 irq after reset", 64'(irq), 64'd0);
        chk("R6 valid after reset", 64'(top_valid), 64'd0);
        bus_read(6'h24, d); chk("R6 enable lo reset", 64'(d), 64'd0);
        bus_read(6'h14, d); chk("R6 enable hi reset", 64'(d), 64'd0);

        // R1 map: banks distinct, unmapped and ack read zero
        bus_write(6'h14, 32'hA5A5_0001);
        bus_read(6'h14, d); chk("R1 hi enable at 0x14", 64'(d), 64'h0000_0000_A5A5_0001);
        bus_read(6'h24, d); chk("R1 lo enable untouched", 64'(d), 64'd0);
        bus_read(6'h04, d); chk("R1 unmapped 0x04", 64'(d), 64'd0);
        bus_read(6'h34, d); chk("R1 unmapped 0x34", 64'(d), 64'd0);
        bus_read(6'h28, d); chk("R1 ack reads zero", 64'(d), 64'd0);
        bus_write(6'h14, 32'h0);

        // R5 enabling a source already high
        drive_src(64'h8);
        bus_write(6'h24, 32'h8);
        settle();
        bus_read(6'h20, d); chk("R5 no event on enable-while-high", 64'(d), 64'd0);
        chk("R5 no request on enable-while-high", 64'(irq), 64'd0);
        drive_src(64'h0);
        drive_src(64'h8);
        bus_read(6'h20, d); chk("R5 later edge latches", 64'(d), 64'h8);
        chk("R5 request after edge", 64'(irq), 64'd1);
        chk("R8 num 3", 64'(top_num), 64'd3);

        // R3 ack with zero and with one
        bus_write(6'h28, 32'h0);
        bus_read(6'h20, d); chk("R3 zero ack keeps event", 64'(d), 64'h8);
        bus_write(6'h28, 32'h8);
        bus_read(6'h20, d); chk("R3 ack clears event", 64'(d), 64'd0);
        chk("R3 request drops", 64'(irq), 64'd0);

        // R7 level type source 20
        bus_write(6'h24, 32'h0010_0008);
        drive_src(64'h0010_0000);
        bus_read(6'h20, d); chk("R7 level no event", 64'(d), 64'd0);
        chk("R7 level pending", 64'(irq), 64'd1);
        chk("R7 num 20", 64'(top_num), 64'd20);
        bus_read(6'h2C, d); chk("R10 level reg", 64'(d), 64'h0010_0000);

        // R8 high bank wins
        bus_write(6'h14, 32'h2);
        drive_src(64'h0000_0002_0010_0000);
        chk("R8 high bank first", 64'(top_num), 64'd33);
        drive_src(64'h0000_0000_0000_0000);
        chk("R8 edge 33 stays latched", 64'(top_num), 64'd33);
        bus_write(6'h18, 32'h2);
        chk("R8 valid low when none", 64'(top_valid), 64'd0);

        // R10 writes to event/level ignored
        drive_src(64'h8);
        bus_write(6'h20, 32'hFFFF_FFFF);
        bus_write(6'h2C, 32'hFFFF_FFFF);
        bus_write(6'h1C, 32'hFFFF_FFFF);
        bus_read(6'h20, d); chk("R10 event write ignored", 64'(d), 64'h8);
        bus_read(6'h2C, d); chk("R10 level write ignored", 64'(d), 64'h8);
        check_outputs("directed");

        // random phase
        for (int it = 0; it < 250; it++) begin
            int op;
            op = $urandom_range(0, 5);
            case (op)
                0, 1: drive_src(irq_src ^ {$urandom(), $urandom()});
                2: bus_write(($urandom_range(0, 1) != 0) ? 6'h24 : 6'h14, $urandom());
                3: bus_write(($urandom_range(0, 1) != 0) ? 6'h28 : 6'h18, $urandom());
                4: bus_write(($urandom_range(0, 1) != 0) ? 6'h20 : 6'h1C, $urandom());
                default: settle();
            endcase
            check_outputs("random");
            if ((it % 25) == 0) check_regs("random");
        end
        check_regs("final");

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule